// File: doc/BRIEF.md
# Boot-Time Network Address Selector

This controller runs once after reset and settles which MAC address and IPv4 address a network endpoint will use. It first fetches a four-word configuration record through a simple request/valid memory-read port. A signature in the first word decides whether the record counts as valid. The record also carries a MAC, an IP and a flag that asks for a dynamically assigned address.

When the record is valid and the flag is set, or when the record is invalid, the controller issues one request to an external dynamic-address client. It then waits a bounded number of cycles for that client to answer. The MAC and the IP are decided independently. The MAC comes from the record or from a fixed default. The IP comes from the client's answer, from the record or from a second fixed default.

When the decision is made, the chosen pair appears on the outputs with a one-cycle done strobe. The outputs then stay frozen until the next reset.

Top module: `boot_addr_sel`

## Requirements
- R1: After reset `macAddr` and `ipAddr` are zero and `doneStrobe` is low. The controller reads record words one at a time, at addresses `BASE_ADDR+0`, `+1`, `+2` and `+3` in that order, and only issues the next read after `rdValid` has returned the previous word.
- R2: A record is valid when word 0 equals `SIGNATURE`. With a valid record the MAC is `{word2[15:0], word1[31:0]}`.
- R3: With an invalid record the MAC is 48'h0007ED012345, whatever the other words hold.
- R4: With a valid record whose dynamic flag (word2 bit 16) is clear, no dynamic request is issued and the IP is word 3.
- R5: With a valid record and the flag set, a request is issued; a response with `dynOk` high makes the IP equal to `dynIp`.
- R6: With a valid record and the flag set, a response with `dynOk` low, or no response before the timeout, makes the IP equal to word 3.
- R7: With an invalid record a request is always issued; success gives `dynIp`, failure or timeout gives 32'hC0A80119 (192.168.1.25).
- R8: The wait lasts `TIMEOUT_CYC` cycles, counting the cycle in which `dynReq` is high as cycle 1. A response in cycle `TIMEOUT_CYC` is still accepted; a later one is ignored.
- R9: `dynReq` is a one-cycle pulse and is issued at most once per reset.
- R10: `doneStrobe` pulses for exactly one cycle, in the cycle the final values first appear. After that, `macAddr` and `ipAddr` hold steady and ignore any further client response until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | output | 1 | Record word read request (one cycle) |
| rdAddr | output | ADDR_W | Address of the requested record word |
| rdValid | input | 1 | Read data valid |
| rdData | input | 32 | Read data word |
| dynReq | output | 1 | Dynamic-address request pulse |
| dynDone | input | 1 | Client response present |
| dynOk | input | 1 | Client obtained an address (qualifies dynDone) |
| dynIp | input | 32 | Address returned by the client |
| macAddr | output | 48 | Selected MAC address |
| ipAddr | output | 32 | Selected IPv4 address |
| doneStrobe | output | 1 | One-cycle pulse when the selection is final |

## Verification
The hardest point to reach is the edge of the timeout window. A client answer in exactly cycle `TIMEOUT_CYC` must win, while one a cycle later must be dropped in favour of a fallback. The bench's client model counts cycles from the sampled request pulse and answers on a chosen cycle, so both sides of the edge are driven on purpose. The same model sends a stray answer after completion to show that the outputs are frozen. Record contents are also varied: a signature one bit off hides otherwise plausible MAC and IP words, which separates the two fallback constants.

// File: rtl/boot_addr_pkg.sv
package boot_addr_pkg;

  localparam int REC_WORDS = 4;
  localparam int IDX_W = $clog2(REC_WORDS);

  localparam logic [47:0] DEFAULT_MAC = 48'h0007ED012345;
  localparam logic [31:0] DEFAULT_IP  = 32'hC0A80119;

  typedef enum logic [2:0] {
    IDLE,
    READ_RECORD,
    CHECK,
    DHCP_WAIT,
    DONE
  } selState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] capIdx;
    logic             commit;
    logic             useDyn;
  } selStrobe_t;

endpackage

// File: rtl/boot_addr_dp.sv
module boot_addr_dp
  import boot_addr_pkg::*;
#(
  parameter logic [31:0] SIGNATURE = 32'h5AFEC0DE
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] rdData,
  input  selStrobe_t  strobe,
  input  logic [31:0] dynIp,
  output logic        recValid,
  output logic        dynEn,
  output logic [47:0] macAddr,
  output logic [31:0] ipAddr
);

  logic [31:0] sigWord;
  logic [31:0] macLo;
  logic [15:0] macHi;
  logic        flagBit;
  logic [31:0] ipRec;
  logic        committed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigWord <= '0;
      macLo   <= '0;
      macHi   <= '0;
      flagBit <= 1'b0;
      ipRec   <= '0;
    end else if (strobe.capture) begin
      case (strobe.capIdx)
        IDX_W'(0): sigWord <= rdData;
        IDX_W'(1): macLo   <= rdData;
        IDX_W'(2): begin
          macHi   <= rdData[15:0];
          flagBit <= rdData[16];
        end
        default:   ipRec   <= rdData;
      endcase
    end
  end

  assign recValid = (sigWord == SIGNATURE);
  assign dynEn    = flagBit;

  // MAC and IP decided on separate paths
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      macAddr   <= '0;
      ipAddr    <= '0;
      committed <= 1'b0;
    end else if (strobe.commit && !committed) begin
      committed <= 1'b1;
      macAddr   <= recValid ? {macHi, macLo} : DEFAULT_MAC;
      if (strobe.useDyn)
        ipAddr <= dynIp;
      else
        ipAddr <= recValid ? ipRec : DEFAULT_IP;
    end
  end

  // R10: frozen once committed
  a_r10_outputs_frozen: assert property (@(posedge clk) disable iff (!rstN)
    committed |=> ($stable(macAddr) && $stable(ipAddr)));

  // R3: invalid record forces the default MAC
  a_r3_default_mac: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !committed && !recValid) |=> (macAddr == DEFAULT_MAC));

  // R7: invalid record without dynamic success forces the default IP
  a_r7_default_ip: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !committed && !recValid && !strobe.useDyn) |=> (ipAddr == DEFAULT_IP));

endmodule

// File: rtl/boot_addr_ctrl.sv
module boot_addr_ctrl
  import boot_addr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BASE_ADDR   = 16,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  output logic              dynReq,
  input  logic              dynDone,
  input  logic              dynOk,
  input  logic              recValid,
  input  logic              dynEn,
  output selStrobe_t        strobe,
  output logic              doneStrobe
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE_ADDR);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(REC_WORDS - 1);

  selState_t        state;
  logic [IDX_W-1:0] wordIdx;
  logic             pend;
  logic [CNT_W-1:0] waitCnt;
  logic             lastWait;

  assign rdEn     = (state == READ_RECORD) && !pend;
  assign rdAddr   = BASE_A + ADDR_W'(wordIdx);
  assign lastWait = (waitCnt == LAST_CNT);

  always_comb begin
    strobe         = '0;
    strobe.capture = (state == READ_RECORD) && pend && rdValid;
    strobe.capIdx  = wordIdx;
    case (state)
      CHECK:     strobe.commit = recValid && !dynEn;
      DHCP_WAIT: begin
        strobe.commit = dynDone || lastWait;
        strobe.useDyn = dynDone && dynOk;
      end
      default:   strobe.commit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= IDLE;
      wordIdx    <= '0;
      pend       <= 1'b0;
      waitCnt    <= '0;
      dynReq     <= 1'b0;
      doneStrobe <= 1'b0;
    end else begin
      dynReq     <= 1'b0;
      doneStrobe <= 1'b0;
      case (state)
        IDLE: begin
          state   <= READ_RECORD;
          wordIdx <= '0;
          pend    <= 1'b0;
        end
        READ_RECORD: begin
          if (rdEn) begin
            pend <= 1'b1;
          end else if (rdValid) begin
            pend    <= 1'b0;
            wordIdx <= wordIdx + 1'b1;
            if (wordIdx == LAST_IDX) state <= CHECK;
          end
        end
        CHECK: begin
          if (strobe.commit) begin
            state      <= DONE;
            doneStrobe <= 1'b1;
          end else begin
            state   <= DHCP_WAIT;
            dynReq  <= 1'b1;
            waitCnt <= '0;
          end
        end
        DHCP_WAIT: begin
          if (strobe.commit) begin
            state      <= DONE;
            doneStrobe <= 1'b1;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: state <= DONE;
      endcase
    end
  end

  // checker-side count of requests seen since reset
  logic [1:0] reqSeenCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqSeenCnt <= '0;
    else if (dynReq && reqSeenCnt != 2'd3) reqSeenCnt <= reqSeenCnt + 1'b1;
  end

  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dynReq |=> !dynReq);

  a_r9_one_req: assert property (@(posedge clk) disable iff (!rstN)
    reqSeenCnt <= 2'd1);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == DHCP_WAIT) |-> (waitCnt <= LAST_CNT));

  a_r1_one_read_open: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> !rdEn);

endmodule

// File: rtl/boot_addr_sel.sv
module boot_addr_sel
  import boot_addr_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          BASE_ADDR   = 16,
  parameter int          TIMEOUT_CYC = 1000,
  parameter logic [31:0] SIGNATURE   = 32'h5AFEC0DE
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [31:0]       rdData,
  output logic              dynReq,
  input  logic              dynDone,
  input  logic              dynOk,
  input  logic [31:0]       dynIp,
  output logic [47:0]       macAddr,
  output logic [31:0]       ipAddr,
  output logic              doneStrobe
);

  selStrobe_t strobe;
  logic       recValid;
  logic       dynEn;

  boot_addr_ctrl #(
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .rdValid   (rdValid),
    .dynReq    (dynReq),
    .dynDone   (dynDone),
    .dynOk     (dynOk),
    .recValid  (recValid),
    .dynEn     (dynEn),
    .strobe    (strobe),
    .doneStrobe(doneStrobe)
  );

  boot_addr_dp #(
    .SIGNATURE(SIGNATURE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rdData  (rdData),
    .strobe  (strobe),
    .dynIp   (dynIp),
    .recValid(recValid),
    .dynEn   (dynEn),
    .macAddr (macAddr),
    .ipAddr  (ipAddr)
  );

endmodule

// File: tb/boot_addr_sel_tb.sv
module boot_addr_sel_tb;

  localparam int          ADDR_W  = 8;
  localparam int          BASE    = 16;
  localparam int          TO      = 8;
  localparam logic [31:0] SIG     = 32'h5AFEC0DE;
  localparam logic [47:0] DEF_MAC = 48'h0007ED012345;
  localparam logic [31:0] DEF_IP  = 32'hC0A80119;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rdEn;
  logic [ADDR_W-1:0] rdAddr;
  logic              rdValid = 1'b0;
  logic [31:0]       rdData = '0;
  logic              dynReq;
  logic              dynDone = 1'b0;
  logic              dynOk = 1'b0;
  logic [31:0]       dynIp = '0;
  logic [47:0]       macAddr;
  logic [31:0]       ipAddr;
  logic              doneStrobe;

  always #5 clk = ~clk;

  boot_addr_sel #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .TIMEOUT_CYC(TO), .SIGNATURE(SIG)
  ) u_dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .dynReq(dynReq), .dynDone(dynDone), .dynOk(dynOk),
    .dynIp(dynIp), .macAddr(macAddr), .ipAddr(ipAddr), .doneStrobe(doneStrobe)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [47:0] mac;
    logic [31:0] ip;
  } expItem_t;
  expItem_t expQ[$];

  // stimulus globals
  logic [31:0] mem [4];
  int    respMode = 0;   // 0 none, 1 answer
  int    respAt   = 1;
  logic  respOk   = 1'b0;
  logic [31:0] respIp = '0;
  logic  stray = 1'b0;
  string curTag = "";

  // model-side state
  int readIdx = 0;
  int rdCount = 0;
  int reqCount = 0;
  int waitLeft = 0;
  int doneSeen = 0;
  logic prevReq = 1'b0;

  task automatic check(input string req, input logic ok, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, curTag, act, exp);
    end
  endtask

  // memory model: two-cycle latency
  always @(negedge clk) begin
    rdValid = 1'b0;
    if (!rstN) begin
      readIdx = 0;
      rdCount = 0;
    end else begin
      if (rdCount > 0) begin
        rdCount--;
        if (rdCount == 0) begin
          rdData  = mem[readIdx];
          rdValid = 1'b1;
          readIdx++;
        end
      end
      if (rdEn) begin
        // R1: addresses in order
        check("R1", rdAddr == ADDR_W'(BASE + readIdx), 64'(rdAddr), 64'(BASE + readIdx));
        rdCount = 2;
      end
    end
  end

  // dynamic-address client model
  always @(negedge clk) begin
    dynDone = 1'b0;
    dynOk   = 1'b0;
    if (!rstN) begin
      reqCount = 0;
      waitLeft = 0;
    end else begin
      if (dynReq) begin
        reqCount++;
        waitLeft = respAt;
      end
      if (waitLeft > 0) begin
        waitLeft--;
        if (waitLeft == 0 && respMode == 1) begin
          dynDone = 1'b1;
          dynOk   = respOk;
          dynIp   = respIp;
        end
      end
      if (stray) begin
        dynDone = 1'b1;
        dynOk   = 1'b1;
        dynIp   = 32'hDEADBEEF;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      // R9: request is a single-cycle pulse
      if (dynReq && prevReq) check("R9", 1'b0, 64'(2), 64'(1));
      prevReq = dynReq;
      if (doneStrobe) begin
        expItem_t e;
        doneSeen++;
        if (expQ.size() == 0) begin
          check("R10", 1'b0, 64'(1), 64'(0));
        end else begin
          e = expQ.pop_front();
          check("R2/R3 mac", macAddr == e.mac, 64'(macAddr), 64'(e.mac));
          check("R4-R8 ip", ipAddr == e.ip, 64'(ipAddr), 64'(e.ip));
        end
      end
    end else begin
      prevReq = 1'b0;
    end
  end

  task automatic scenario(input string tag, input logic [31:0] s, input logic [47:0] m,
                          input logic f, input logic [31:0] ip, input int mode,
                          input int at, input logic ok, input logic [31:0] dip);
    expItem_t e;
    logic     validRec;
    logic     wantReq;
    logic     dynWin;
    logic [47:0] holdMac;
    logic [31:0] holdIp;
    int       startDone;
    curTag = tag;
    mem[0] = s;
    mem[1] = m[31:0];
    mem[2] = {15'h0, f, m[47:32]};
    mem[3] = ip;
    respMode = mode;
    respAt   = at;
    respOk   = ok;
    respIp   = dip;
    // expected values from the requirements
    validRec = (s == SIG);
    wantReq  = !validRec || f;
    dynWin   = wantReq && mode == 1 && ok && at <= TO;
    e.mac = validRec ? m : DEF_MAC;
    e.ip  = dynWin ? dip : (validRec ? ip : DEF_IP);
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", macAddr == '0 && ipAddr == '0 && !doneStrobe,
          {macAddr[31:0], ipAddr}, 64'(0));
    expQ.push_back(e);
    startDone = doneSeen;
    rstN = 1'b1;
    while (doneSeen == startDone) @(negedge clk);
    holdMac = macAddr;
    holdIp  = ipAddr;
    // R10: stray answer after completion is ignored
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    repeat (TO + 3) @(negedge clk);
    check("R10 hold", macAddr == holdMac && ipAddr == holdIp,
          {macAddr[31:0], ipAddr}, {holdMac[31:0], holdIp});
    // R4/R7/R9: request count
    check("R9 req count", reqCount == (wantReq ? 1 : 0), 64'(reqCount),
          64'(wantReq ? 1 : 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    scenario("R2 R4 valid no flag", SIG, 48'h112233445566, 1'b0, 32'h0A000005, 0, 1, 1'b0, 32'h0);
    scenario("R5 valid flag ok", SIG, 48'hA0B1C2D3E4F5, 1'b1, 32'h0A000006, 1, 3, 1'b1, 32'hAC100101);
    scenario("R6 valid flag fail", SIG, 48'h020406080A0C, 1'b1, 32'h0A000007, 1, 2, 1'b0, 32'hAC100102);
    scenario("R6 valid flag timeout", SIG, 48'h0F0E0D0C0B0A, 1'b1, 32'h0A000008, 0, 1, 1'b0, 32'h0);
    scenario("R3 R7 invalid ok", 32'h0, 48'h112233445566, 1'b0, 32'h0A000009, 1, 1, 1'b1, 32'hAC100103);
    scenario("R7 invalid timeout", 32'h12345678, 48'hFFFFFFFFFFFF, 1'b0, 32'h0A00000A, 0, 1, 1'b0, 32'h0);
    scenario("R8 last cycle accepted", 32'h0, 48'h0, 1'b0, 32'h0, 1, TO, 1'b1, 32'hAC100104);
    scenario("R8 late ignored", SIG, 48'h665544332211, 1'b1, 32'h0A00000B, 1, TO + 1, 1'b1, 32'hAC100105);
    scenario("R3 sig off by one bit", SIG ^ 32'h1, 48'h123456789ABC, 1'b1, 32'h0A00000C, 1, 4, 1'b0, 32'hAC100106);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule